// File: doc/BRIEF.md
# Comma Word Aligner with Recovered Clock

This block runs in the bit-clock domain on the receive side of a serial link. It shifts in one recovered bit per clock, searches every bit time for the 7-bit synchronisation comma, and from it sets both the 10-bit character boundary and the phase of a divided recovered clock. Downstream protocol logic receives a parallel character, a pair of complementary recovered clocks running at one tenth or one twentieth of the bit rate, and a flag that marks characters holding a comma.

When alignment is enabled, a comma that does not sit in the expected place makes the block move its character grid so that the comma lands at bits 0 to 6 of an output character. In the divide-by-20 mode the comma is also placed in the character that the rising edge of the true clock output samples. The clock is moved only by holding its present level longer, never by cutting a half period short. When alignment is disabled, the grid stays where it is, whatever the data.

Top module: `comma_word_aligner`

## Requirements
- R1: Output bit 0 of `char_out` is the earliest received bit of a character. The comma is the 7-bit run 0,0,1,1,1,1,1 in arrival order. An aligned comma appears as `char_out[6:0]` = 7'b1111100, where bit 0 is 0 and bits 2 to 6 are 1.
- R2: With `align_en` high, a comma that straddles two characters or is not at bits 0 to 6 moves the grid. Every character sent after that comma then comes out whole and in order.
- R3: A comma that already sits at the aligned position leaves the grid unchanged, and the character after it comes out intact.
- R4: With `div10_sel` low, a comma is placed in the character that is valid at the rising edge of `rclk_p`. A comma that arrives aligned inside the other character of the pair also forces a realignment.
- R5: With `align_en` low, the boundary found at reset is kept regardless of data. In that case 13 zero bits followed by a comma give a character of 10'h3E0, and `comma_flag` stays low (one clock after `align_en` falls at the latest).
- R6: `comma_flag` is high exactly while `char_out` holds a flagged comma character, which is one character time (10 bit clocks). It is low for data characters.
- R7: With `div10_sel` high, `rclk_p` has a period of 10 bit clocks and is high for 5 of them. With it low, the period is 20 and `rclk_p` is high for 10. `rclk_n` is always the complement of `rclk_p`.
- R8: No high or low phase of `rclk_p` is ever shorter than the nominal half period (5 or 10 bit clocks), including across a realignment.
- R9: The recovered clocks keep toggling when the serial input carries no transitions.
- R10: During reset `char_out` is 0, `comma_flag` is 0, `rclk_p` is 0 and `rclk_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Recovered serial data bit |
| align_en | input | 1 | High enables comma search, realignment and the flag |
| div10_sel | input | 1 | High: clocks at 1/10 bit rate; low: 1/20 |
| char_out | output | CHAR_W | Parallel character, bit 0 received first |
| rclk_p | output | 1 | Recovered clock, true phase |
| rclk_n | output | 1 | Recovered clock, complement phase |
| comma_flag | output | 1 | High while `char_out` holds a comma character |

## Verification
The bench sends serial streams built from 8b/10b-like characters. The first has a comma offset by three bits from the reset grid; its clean data afterwards separates realignment from boundary drift, and a second comma that is already aligned shows that such a comma leaves the grid alone. The same stream with alignment disabled must give the exact shifted words predicted from the reset boundary, which separates "kept" from "realigned". A divide-by-20 stream places the comma in the wrong half of the clock pair, so that the clock phase chosen for each captured character can be checked. Idle input exercises the free-running clocks, and the shortest high or low phase is tracked across every realignment.

// File: rtl/comma_align_pkg.sv
`timescale 1ns/1ps
package comma_align_pkg;

   // grid events produced once per bit time
   typedef struct packed {
      logic realign;   // grid jumps to the comma target position
      logic load;      // a character boundary is reached this bit
      logic load_a;    // the boundary closes the clock-sampled character
   } grid_evt_t;

endpackage

// File: rtl/comma_window.sv
`timescale 1ns/1ps
module comma_window #(
   parameter int unsigned CHAR_W = 10,
   parameter int unsigned COMMA_W = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bit,
   output logic [CHAR_W-1:0] shift_next,
   output logic              hit
);

   logic [CHAR_W-1:0]  shreg;
   logic [COMMA_W-1:0] window;
   logic [COMMA_W-1:0] bit_eq;

   // newest bit enters at the top, so bit 0 is the oldest of the last CHAR_W
   assign shift_next = {ser_bit, shreg[CHAR_W-1:1]};
   assign window     = shift_next[CHAR_W-1 -: COMMA_W];

   for (genvar i = 0; i < COMMA_W; i++) begin : g_cmp
      assign bit_eq[i] = window[i] ~^ COMMA_PAT[i];
   end

   assign hit = &bit_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= shift_next;
   end

endmodule

// File: rtl/bit_grid.sv
`timescale 1ns/1ps
module bit_grid
   import comma_align_pkg::*;
#(
   parameter int unsigned CHAR_W = 10,
   parameter int unsigned COMMA_W = 7,
   localparam int unsigned PW = $clog2(2 * CHAR_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          div10,
   input  logic          align_en,
   input  logic          hit,
   output logic [PW-1:0] pos,
   output logic [PW-1:0] pos_next,
   output grid_evt_t     evt
);

   localparam logic [PW-1:0] LAST10 = PW'(CHAR_W - 1);
   localparam logic [PW-1:0] LAST20 = PW'(2 * CHAR_W - 1);
   localparam logic [PW-1:0] TGT10  = PW'(COMMA_W);
   localparam logic [PW-1:0] TGT20  = PW'(CHAR_W + COMMA_W);
   localparam logic [PW-1:0] ONE    = PW'(1);

   logic [PW-1:0] last_pos;
   logic [PW-1:0] target;
   logic [PW-1:0] step;
   logic          aligned;
   logic          boundary;

   always_comb begin
      last_pos = div10 ? LAST10 : LAST20;
      target   = div10 ? TGT10 : TGT20;
      // the seventh comma bit belongs one position before the target
      aligned  = (pos == target - ONE);
      step     = (pos >= last_pos) ? '0 : pos + ONE;

      evt.realign = align_en & hit & ~aligned;
      pos_next    = evt.realign ? target : step;

      boundary    = (pos == LAST10) | (pos == LAST20);
      evt.load    = boundary & ~evt.realign;
      evt.load_a  = evt.load & (div10 | (pos == LAST20));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= '0;
      else        pos <= pos_next;
   end

endmodule

// File: rtl/rclk_former.sv
`timescale 1ns/1ps
module rclk_former #(
   parameter int unsigned CHAR_W = 10,
   parameter bit COMPL_REG = 1'b1,
   localparam int unsigned PW = $clog2(2 * CHAR_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          div10,
   input  logic [PW-1:0] pos,
   input  logic [PW-1:0] pos_next,
   input  logic          realign,
   output logic          rclk_p,
   output logic          rclk_n
);

   localparam logic [PW-1:0] RISE   = PW'(CHAR_W / 2);
   localparam logic [PW-1:0] FALL10 = PW'(CHAR_W);
   localparam logic [PW-1:0] FALL20 = PW'(CHAR_W / 2 + CHAR_W);

   function automatic logic grid_lvl(input logic [PW-1:0] p, input logic d10);
      return (p >= RISE) && (p < (d10 ? FALL10 : FALL20));
   endfunction

   logic hold;
   logic hold_d;
   logic rclk_q;
   logic rclk_d;
   logic lvl_now;
   logic lvl_new;

   always_comb begin
      lvl_now = grid_lvl(pos, div10);
      lvl_new = grid_lvl(pos_next, div10);
      hold_d  = hold;
      rclk_d  = rclk_q;
      if (realign) begin
         // freeze the present level; the grid just jumped
         hold_d = 1'b1;
      end else if (hold) begin
         // resume only on a fresh grid edge into the frozen level
         if (lvl_new == rclk_q && lvl_now != rclk_q) hold_d = 1'b0;
      end else begin
         rclk_d = lvl_new;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold   <= 1'b0;
         rclk_q <= 1'b0;
      end else begin
         hold   <= hold_d;
         rclk_q <= rclk_d;
      end
   end

   assign rclk_p = rclk_q;

   if (COMPL_REG) begin : g_compl_reg
      logic rclkn_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rclkn_q <= 1'b1;
         else        rclkn_q <= ~rclk_d;
      end
      assign rclk_n = rclkn_q;
   end else begin : g_compl_inv
      assign rclk_n = ~rclk_q;
   end

endmodule

// File: rtl/char_capture.sv
`timescale 1ns/1ps
module char_capture #(
   parameter int unsigned CHAR_W = 10,
   parameter int unsigned COMMA_W = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              align_en,
   input  logic              load,
   input  logic              load_a,
   input  logic [CHAR_W-1:0] shift_next,
   output logic [CHAR_W-1:0] char_out,
   output logic              comma_flag
);

   logic at_head;

   assign at_head = (shift_next[COMMA_W-1:0] == COMMA_PAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         char_out   <= '0;
         comma_flag <= 1'b0;
      end else if (load) begin
         char_out   <= shift_next;
         comma_flag <= align_en & load_a & at_head;
      end else begin
         comma_flag <= comma_flag & align_en;
      end
   end

endmodule

// File: rtl/comma_word_aligner.sv
`timescale 1ns/1ps
module comma_word_aligner
   import comma_align_pkg::*;
#(
   parameter int unsigned CHAR_W = 10,
   parameter int unsigned COMMA_W = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100,
   parameter bit COMPL_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bit,
   input  logic              align_en,
   input  logic              div10_sel,
   output logic [CHAR_W-1:0] char_out,
   output logic              rclk_p,
   output logic              rclk_n,
   output logic              comma_flag
);

   localparam int unsigned PW = $clog2(2 * CHAR_W);

   if (CHAR_W % 2 != 0) begin : g_bad_even
      $error("CHAR_W must be even");
   end
   if (COMMA_W < 2 || COMMA_W >= CHAR_W) begin : g_bad_comma
      $error("COMMA_W must be at least 2 and below CHAR_W");
   end

   logic [CHAR_W-1:0] shift_next;
   logic              hit;
   logic [PW-1:0]     pos;
   logic [PW-1:0]     pos_next;
   grid_evt_t         evt;

   comma_window #(
      .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
   ) i_window (
      .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit),
      .shift_next(shift_next), .hit(hit)
   );

   bit_grid #(
      .CHAR_W(CHAR_W), .COMMA_W(COMMA_W)
   ) i_grid (
      .clk(clk), .rst_n(rst_n), .div10(div10_sel), .align_en(align_en),
      .hit(hit), .pos(pos), .pos_next(pos_next), .evt(evt)
   );

   rclk_former #(
      .CHAR_W(CHAR_W), .COMPL_REG(COMPL_REG)
   ) i_clk (
      .clk(clk), .rst_n(rst_n), .div10(div10_sel), .pos(pos),
      .pos_next(pos_next), .realign(evt.realign),
      .rclk_p(rclk_p), .rclk_n(rclk_n)
   );

   char_capture #(
      .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
   ) i_cap (
      .clk(clk), .rst_n(rst_n), .align_en(align_en), .load(evt.load),
      .load_a(evt.load_a), .shift_next(shift_next),
      .char_out(char_out), .comma_flag(comma_flag)
   );

endmodule

// File: rtl/comma_word_aligner_chk.sv
`timescale 1ns/1ps
module comma_word_aligner_chk #(
   parameter int unsigned CHAR_W = 10,
   parameter int unsigned COMMA_W = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              align_en,
   input logic              div10_sel,
   input logic [CHAR_W-1:0] char_out,
   input logic              rclk_p,
   input logic              rclk_n,
   input logic              comma_flag
);

   localparam int unsigned RW = $clog2(CHAR_W + 1);
   localparam logic [RW-1:0] HALF10 = RW'(CHAR_W / 2);
   localparam logic [RW-1:0] HALF20 = RW'(CHAR_W);
   localparam logic [RW-1:0] ONE    = RW'(1);

   logic [RW-1:0] run;
   logic          prev_p;

   // length of the current rclk_p level, saturating at a full character
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= HALF20;
         prev_p <= 1'b0;
      end else begin
         prev_p <= rclk_p;
         if (rclk_p != prev_p) run <= ONE;
         else if (run < HALF20) run <= run + ONE;
      end
   end

   assert_compl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rclk_n == ~rclk_p);

   assert_no_short_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rclk_p != prev_p) |-> (run >= (div10_sel ? HALF10 : HALF20)));

   assert_flag_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !align_en |=> !comma_flag);

   assert_flag_comma_R6: assert property (@(posedge clk) disable iff (!rst_n)
      comma_flag |-> (char_out[COMMA_W-1:0] == COMMA_PAT));

endmodule

bind comma_word_aligner comma_word_aligner_chk #(
   .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
) i_chk (
   .clk(clk), .rst_n(rst_n), .align_en(align_en), .div10_sel(div10_sel),
   .char_out(char_out), .rclk_p(rclk_p), .rclk_n(rclk_n),
   .comma_flag(comma_flag)
);

// File: tb/test_comma_word_aligner.sv
`timescale 1ns/1ps
module test_comma_word_aligner;

   localparam logic [9:0] COMMA_CHAR = 10'h17C;   // bits0..9 = 0011111010
   localparam logic [9:0] DATA [0:5] = '{10'h2AA, 10'h155, 10'h0CC,
                                         10'h333, 10'h1B6, 10'h24D};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_bit = 1'b0;
   logic       align_en = 1'b1;
   logic       div10_sel = 1'b1;
   logic [9:0] char_out;
   logic       rclk_p, rclk_n, comma_flag;

   always #2.5 clk = ~clk;

   comma_word_aligner i_comma_word_aligner (
      .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .align_en(align_en),
      .div10_sel(div10_sel), .char_out(char_out), .rclk_p(rclk_p),
      .rclk_n(rclk_n), .comma_flag(comma_flag)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // capture log, written only by the monitor
   logic [9:0] lg_c [0:255];
   logic       lg_f [0:255];
   logic       lg_p [0:255];
   int         lg_n;
   int         min_run, cur_run, flag_run, last_flag_run, flag_highs, compl_bad;
   bit         seen_edge;
   logic       q_p, q_n, q_f;

   always @(negedge clk) begin
      if (!rst_n) begin
         lg_n = 0; min_run = 1000; cur_run = 0; seen_edge = 0;
         flag_run = 0; last_flag_run = 0; flag_highs = 0; compl_bad = 0;
         q_p = rclk_p; q_n = rclk_n; q_f = comma_flag;
      end else begin
         if (rclk_n !== ~rclk_p) compl_bad++;
         if (rclk_p != q_p) begin
            if (seen_edge && cur_run < min_run) min_run = cur_run;
            seen_edge = 1; cur_run = 1;
         end else cur_run++;
         if (rclk_p && !q_p && lg_n < 256) begin
            lg_c[lg_n] = char_out; lg_f[lg_n] = comma_flag; lg_p[lg_n] = 1'b1; lg_n++;
         end
         if (!div10_sel && rclk_n && !q_n && lg_n < 256) begin
            lg_c[lg_n] = char_out; lg_f[lg_n] = comma_flag; lg_p[lg_n] = 1'b0; lg_n++;
         end
         if (comma_flag) begin flag_run++; flag_highs++; end
         else if (q_f) begin last_flag_run = flag_run; flag_run = 0; end
         q_p = rclk_p; q_n = rclk_n; q_f = comma_flag;
      end
   end

   logic [9:0] ex_c [0:7];
   logic       ex_f [0:7];
   logic       ex_p [0:7];
   int         ex_n;

   function automatic bit seq_found();
      for (int i = 0; i + ex_n <= lg_n; i++) begin
         bit ok = 1'b1;
         for (int j = 0; j < ex_n; j++)
            if (lg_c[i+j] != ex_c[j] || lg_f[i+j] != ex_f[j] || lg_p[i+j] != ex_p[j])
               ok = 1'b0;
         if (ok) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic d10, input logic en);
      @(negedge clk);
      rst_n = 1'b0; div10_sel = d10; align_en = en; ser_bit = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send_bit(input logic b);
      ser_bit = b;
      @(negedge clk);
   endtask

   task automatic send_char(input logic [9:0] c);
      for (int i = 0; i < 10; i++) send_bit(c[i]);
   endtask

   task automatic send_zeros(input int n);
      for (int i = 0; i < n; i++) send_bit(1'b0);
   endtask

   task automatic measure(output int per, output int hi);
      logic q;
      int   c;
      q = rclk_p;
      forever begin
         @(negedge clk);
         if (rclk_p && !q) break;
         q = rclk_p;
      end
      c = 0;
      while (rclk_p) begin @(negedge clk); c++; end
      hi = c;
      while (!rclk_p) begin @(negedge clk); c++; end
      per = c;
   endtask

   task automatic push_exp(input logic [9:0] c, input logic f, input logic p);
      ex_c[ex_n] = c; ex_f[ex_n] = f; ex_p[ex_n] = p; ex_n++;
   endtask

   initial begin
      int per, hi;

      // R10: reset state
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(char_out == 10'h000, "R10 char_out", char_out, 0);
      check(comma_flag == 1'b0, "R10 comma_flag", comma_flag, 0);
      check(rclk_p == 1'b0, "R10 rclk_p", rclk_p, 0);
      check(rclk_n == 1'b1, "R10 rclk_n", rclk_n, 1);

      // R7 / R9: divide-by-10 clock with idle input
      do_reset(1'b1, 1'b1);
      measure(per, hi);
      check(per == 10, "R7 R9 period div10", per, 10);
      check(hi == 5, "R7 R9 high time div10", hi, 5);

      // R7 / R9: divide-by-20 clock with idle input
      do_reset(1'b0, 1'b1);
      measure(per, hi);
      check(per == 20, "R7 R9 period div20", per, 20);
      check(hi == 10, "R7 R9 high time div20", hi, 10);

      // R1 R2 R3 R6 R8: misaligned comma, table of data, then aligned comma
      do_reset(1'b1, 1'b1);
      send_zeros(13);
      send_char(COMMA_CHAR);
      for (int k = 0; k < 6; k++) send_char(DATA[k]);
      send_char(COMMA_CHAR);
      send_char(DATA[0]);
      send_zeros(40);
      ex_n = 0;
      for (int k = 0; k < 6; k++) push_exp(DATA[k], 1'b0, 1'b1);
      push_exp(COMMA_CHAR, 1'b1, 1'b1);
      push_exp(DATA[0], 1'b0, 1'b1);
      check(seq_found(), "R2 R3 R1 data after realign div10", lg_n, ex_n);
      check(last_flag_run == 10, "R6 flag length div10", last_flag_run, 10);
      check(min_run >= 5, "R8 shortest half div10", min_run, 5);
      check(compl_bad == 0, "R7 complement div10", compl_bad, 0);

      // R5 R1: alignment disabled keeps the reset boundary
      do_reset(1'b1, 1'b0);
      send_zeros(13);
      send_char(COMMA_CHAR);
      send_char(DATA[0]);
      send_zeros(30);
      ex_n = 0;
      push_exp(10'h3E0, 1'b0, 1'b1);
      push_exp(10'h152, 1'b0, 1'b1);
      push_exp(10'h005, 1'b0, 1'b1);
      check(seq_found(), "R5 R1 boundary kept", lg_n, ex_n);
      check(flag_highs == 0, "R5 flag stays low", flag_highs, 0);

      // R4 R6 R8: divide-by-20, comma first lands in the wrong half
      do_reset(1'b0, 1'b1);
      send_zeros(20);
      send_char(COMMA_CHAR);
      for (int k = 0; k < 5; k++) send_char(DATA[k]);
      send_char(COMMA_CHAR);
      send_char(DATA[5]);
      send_zeros(60);
      ex_n = 0;
      for (int k = 0; k < 5; k++) push_exp(DATA[k], 1'b0, (k % 2 == 1));
      push_exp(COMMA_CHAR, 1'b1, 1'b1);
      push_exp(DATA[5], 1'b0, 1'b0);
      check(seq_found(), "R4 comma on rclk_p character div20", lg_n, ex_n);
      check(last_flag_run == 10, "R6 flag length div20", last_flag_run, 10);
      check(min_run >= 10, "R8 shortest half div20", min_run, 10);
      check(compl_bad == 0, "R7 complement div20", compl_bad, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule